// File: doc/BRIEF.md
# Output Driver Impedance Calibration Sequencer

This block tunes the drive strength of a pad driver against an off-chip precision resistor. It runs two sweeps in a fixed order: first the pull-down (NFET) leg, then the pull-up (PFET) leg. In each sweep it presents a rising trial code to the pad's analog front end and samples a comparator. The first code at which the comparator reports a match becomes that leg's result. If no code matches, the result stays at the saturated default of 16. A count of 16 on both legs therefore marks a calibration that failed or never ran.

Only the master instance sees the resistor. When both sweeps have finished, the master loads its own status registers. Its paired slave channel then copies those values. Codes travel one way only, from master to slave, so slave defaults can never overwrite calibrated codes. Each side raises a request towards its channel controller and holds it until that controller acknowledges. If both acknowledgements do not arrive within a bounded window, the run still completes but raises a timeout flag.

A shadow copy of the codes from the first calibration after reset is kept. Software may write those codes into both the master and the slave status registers, but only while the sequencer is idle or finished.

Top module: `drv_imp_cal`

## Requirements
- R1: After reset, all four status codes (master NFET/PFET, slave NFET/PFET) read 16, and busy_o, done_o, timeout_o, req_mst_o and req_slv_o are low.
- R2: A start_i pulse seen while idle or done begins a run. busy_o is high from the next cycle until the run ends. The NFET sweep runs first with trial_p_o low, then the PFET sweep runs with trial_p_o high.
- R3: Within a sweep, trial_code_o starts at 0 and rises by exactly one per step. Each code is held for settle_i+1 clocks, and cmp_i is sampled on the last of those clocks.
- R4: A sweep's result is the first code at which cmp_i was sampled as 1. If no code from 0 to 15 gives a 1, the result is 16.
- R5: The master status codes take the two sweep results. The slave status codes are then copied from the master and are never a source for the master, so at done the slave and master codes are equal.
- R6: During the acknowledge wait, req_mst_o and req_slv_o are high, and each drops once its own acknowledge (ack_mst_i, ack_slv_i) has been seen. When both have been seen, done_o rises with timeout_o low.
- R7: If both acknowledges have not been seen within ACK_LIMIT wait cycles, done_o rises with timeout_o high, and the calibrated codes are still published.
- R8: The shadow copy captures the two results of the first calibration after reset only. Later runs do not change it.
- R9: A shadow_apply_i pulse while idle or done writes the shadow codes into both the master and the slave status registers. While a run is in progress the pulse is ignored.
- R10: done_o and timeout_o are low in the cycle after a new run is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins a calibration run |
| settle_i | input | WAIT_W | Extra clocks each trial code is held before comparison |
| cmp_i | input | 1 | Comparator result from the calibration pad |
| trial_code_o | output | CODE_W | Drive code currently presented to the pad |
| trial_p_o | output | 1 | High during the PFET sweep |
| ack_mst_i | input | 1 | Acknowledge from the master's channel controller |
| ack_slv_i | input | 1 | Acknowledge from the slave's channel controller |
| req_mst_o | output | 1 | Master request awaiting acknowledge |
| req_slv_o | output | 1 | Slave request awaiting acknowledge |
| shadow_apply_i | input | 1 | Software pulse copying the shadow codes into both status sets |
| mst_n_o | output | CODE_W | Master NFET status code |
| mst_p_o | output | CODE_W | Master PFET status code |
| slv_n_o | output | CODE_W | Slave NFET status code |
| slv_p_o | output | CODE_W | Slave PFET status code |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| timeout_o | output | 1 | Last run finished without both acknowledges |

## Verification
On every cycle, the assertions check the following:
- the sweep code steps by one and holds through its settle window;
- results never exceed 16;
- the PFET sweep only follows the NFET sweep;
- the master codes stay still during a sweep;
- requests appear only in the acknowledge wait;
- a finished run leaves the slave equal to the master.

Only the bench scenarios can show the rest: the exact result for a given comparator threshold, saturation when no match occurs, and the timeout path with a silent controller. They also show that the shadow keeps the first run's codes across later runs, that an apply pulse is honoured after a run but ignored during one, and the exact hold length of a trial code.

// File: rtl/drv_imp_cal_pkg.sv
package drv_imp_cal_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_NCAL = 3'd1,
      ST_PCAL = 3'd2,
      ST_PROP = 3'd3,
      ST_WACK = 3'd4,
      ST_DONE = 3'd5
   } cal_st_e;

   localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/imp_sweep.sv
module imp_sweep #(
   parameter int unsigned CODE_W = 5,
   parameter int unsigned WAIT_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              go_i,
   input  logic [WAIT_W-1:0] settle_i,
   input  logic              cmp_i,
   output logic [CODE_W-1:0] code_o,
   output logic              fin_o,
   output logic [CODE_W-1:0] result_o
);
   localparam logic [CODE_W-1:0] SAT_CODE = CODE_W'(1) << (CODE_W-1);
   localparam logic [CODE_W-1:0] TOP_CODE = SAT_CODE - CODE_W'(1);

   logic              run_q;
   logic [CODE_W-1:0] code_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [CODE_W-1:0] res_q;
   logic              fin_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         code_q <= '0;
         cnt_q  <= '0;
         res_q  <= SAT_CODE;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go_i) begin
            run_q  <= 1'b1;
            code_q <= '0;
            cnt_q  <= '0;
         end else if (run_q) begin
            if (cnt_q != settle_i) begin
               cnt_q <= cnt_q + WAIT_W'(1);
            end else if (cmp_i) begin
               res_q <= code_q;
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end else if (code_q == TOP_CODE) begin
               res_q <= SAT_CODE;
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end else begin
               code_q <= code_q + CODE_W'(1);
               cnt_q  <= '0;
            end
         end
      end
   end

   assign code_o   = code_q;
   assign fin_o    = fin_q;
   assign result_o = res_q;

   // R3: code advances by exactly one while a sweep runs
   a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && $past(run_q) && !$past(go_i) && (code_q != $past(code_q)))
         |-> (code_q == $past(code_q) + CODE_W'(1)));

   // R3: code held until its settle window has elapsed
   a_r3_hold_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run_q) && !$past(go_i) && ($past(cnt_q) != $past(settle_i)))
         |-> (code_q == $past(code_q)));

   // R4: a result never exceeds the saturated default
   a_r4_result_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_q |-> (res_q <= SAT_CODE));
endmodule

// File: rtl/imp_ack_track.sv
module imp_ack_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic wait_i,
   input  logic ack_i,
   output logic got_o,
   output logic req_o
);
   logic got_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      got_q <= 1'b0;
      else if (clr_i)   got_q <= 1'b0;
      else if (wait_i && ack_i) got_q <= 1'b1;
   end

   assign got_o = got_q;
   assign req_o = wait_i && !got_q;

   // R6: a request is never raised once its acknowledge was taken
   a_r6_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(req_o) && $past(ack_i) && wait_i) |-> !req_o);
endmodule

// File: rtl/drv_imp_cal.sv
module drv_imp_cal
   import drv_imp_cal_pkg::*;
#(
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned WAIT_W    = 8,
   parameter int unsigned ACK_LIMIT = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [WAIT_W-1:0] settle_i,
   input  logic              cmp_i,
   output logic [CODE_W-1:0] trial_code_o,
   output logic              trial_p_o,
   input  logic              ack_mst_i,
   input  logic              ack_slv_i,
   output logic              req_mst_o,
   output logic              req_slv_o,
   input  logic              shadow_apply_i,
   output logic [CODE_W-1:0] mst_n_o,
   output logic [CODE_W-1:0] mst_p_o,
   output logic [CODE_W-1:0] slv_n_o,
   output logic [CODE_W-1:0] slv_p_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o
);
   localparam logic [CODE_W-1:0] SAT_CODE = CODE_W'(1) << (CODE_W-1);
   localparam int unsigned       TO_W     = $clog2(ACK_LIMIT + 1);
   localparam logic [TO_W-1:0]   TO_LAST  = TO_W'(ACK_LIMIT - 1);

   if (CODE_W < 2) begin : g_bad_code_w
      $error("CODE_W must be at least 2");
   end
   if (WAIT_W < 1) begin : g_bad_wait_w
      $error("WAIT_W must be at least 1");
   end
   if (ACK_LIMIT < 2) begin : g_bad_ack_limit
      $error("ACK_LIMIT must be at least 2");
   end

   cal_st_e st_q, st_d;
   logic              idle_like;
   logic              sw_go, sw_fin;
   logic [CODE_W-1:0] sw_code, sw_res;
   logic [CODE_W-1:0] n_res_q, p_res_q;
   logic [CODE_W-1:0] mst_n_q, mst_p_q, slv_n_q, slv_p_q;
   logic [CODE_W-1:0] sh_n_q, sh_p_q;
   logic              sh_vld_q;
   logic [TO_W-1:0]   to_cnt_q;
   logic              to_q;
   logic              all_got;
   logic [NUM_CH-1:0] ack_vec, got_vec, req_vec;

   assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE);
   assign sw_go     = (idle_like && start_i) || ((st_q == ST_NCAL) && sw_fin);

   imp_sweep #(.CODE_W(CODE_W), .WAIT_W(WAIT_W)) i_sweep (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .go_i     (sw_go),
      .settle_i (settle_i),
      .cmp_i    (cmp_i),
      .code_o   (sw_code),
      .fin_o    (sw_fin),
      .result_o (sw_res)
   );

   assign ack_vec = {ack_slv_i, ack_mst_i};

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      imp_ack_track i_track (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (st_q == ST_PROP),
         .wait_i (st_q == ST_WACK),
         .ack_i  (ack_vec[g]),
         .got_o  (got_vec[g]),
         .req_o  (req_vec[g])
      );
   end

   assign all_got = &got_vec;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_DONE: if (start_i) st_d = ST_NCAL;
         ST_NCAL:          if (sw_fin)  st_d = ST_PCAL;
         ST_PCAL:          if (sw_fin)  st_d = ST_PROP;
         ST_PROP:                       st_d = ST_WACK;
         ST_WACK: begin
            if (all_got || (to_cnt_q == TO_LAST)) st_d = ST_DONE;
         end
         default:                       st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         n_res_q <= SAT_CODE;
         p_res_q <= SAT_CODE;
      end else if (sw_fin) begin
         if (st_q == ST_NCAL) n_res_q <= sw_res;
         if (st_q == ST_PCAL) p_res_q <= sw_res;
      end
   end

   // master takes results; slave only ever copies from master
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mst_n_q <= SAT_CODE;
         mst_p_q <= SAT_CODE;
         slv_n_q <= SAT_CODE;
         slv_p_q <= SAT_CODE;
      end else if (st_q == ST_PROP) begin
         mst_n_q <= n_res_q;
         mst_p_q <= p_res_q;
      end else if (st_q == ST_WACK) begin
         slv_n_q <= mst_n_q;
         slv_p_q <= mst_p_q;
      end else if (idle_like && shadow_apply_i) begin
         mst_n_q <= sh_n_q;
         mst_p_q <= sh_p_q;
         slv_n_q <= sh_n_q;
         slv_p_q <= sh_p_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_n_q   <= SAT_CODE;
         sh_p_q   <= SAT_CODE;
         sh_vld_q <= 1'b0;
      end else if ((st_q == ST_PROP) && !sh_vld_q) begin
         sh_n_q   <= n_res_q;
         sh_p_q   <= p_res_q;
         sh_vld_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         to_cnt_q <= '0;
         to_q     <= 1'b0;
      end else begin
         if (st_q == ST_PROP)      to_cnt_q <= '0;
         else if (st_q == ST_WACK) to_cnt_q <= to_cnt_q + TO_W'(1);
         if (idle_like && start_i) to_q <= 1'b0;
         else if ((st_q == ST_WACK) && !all_got && (to_cnt_q == TO_LAST)) to_q <= 1'b1;
      end
   end

   assign trial_code_o = sw_code;
   assign trial_p_o    = (st_q == ST_PCAL);
   assign req_mst_o    = req_vec[0];
   assign req_slv_o    = req_vec[1];
   assign mst_n_o      = mst_n_q;
   assign mst_p_o      = mst_p_q;
   assign slv_n_o      = slv_n_q;
   assign slv_p_o      = slv_p_q;
   assign busy_o       = !idle_like;
   assign done_o       = (st_q == ST_DONE);
   assign timeout_o    = to_q;

   // R2: PFET sweep is entered only from the NFET sweep
   a_r2_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_PCAL) |-> (($past(st_q) == ST_NCAL) || ($past(st_q) == ST_PCAL)));

   // R9: master codes cannot change while a sweep is running
   a_r9_no_override_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q == ST_NCAL) || (st_q == ST_PCAL)) |=> ($stable(mst_n_q) && $stable(mst_p_q)));

   // R5: a completed wait leaves the slave equal to the master
   a_r5_slave_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q == ST_DONE) && ($past(st_q) == ST_WACK))
         |-> ((slv_n_q == mst_n_q) && (slv_p_q == mst_p_q)));

   // R6: requests only exist inside the acknowledge wait
   a_r6_req_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_mst_o || req_slv_o) |-> (st_q == ST_WACK));

   // R7: timeout flag only accompanies a finished run or a fresh start
   a_r7_timeout_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timeout_o && !$past(idle_like && start_i)) |-> done_o);
endmodule

// File: tb/test_drv_imp_cal.sv
`timescale 1ns/1ps
module test_drv_imp_cal;
   localparam int CW = 5;
   localparam int WW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [WW-1:0] settle = '0;
   logic          cmp;
   logic [CW-1:0] trial_code;
   logic          trial_p;
   logic          ack_m, ack_s, req_m, req_s;
   logic          apply = 1'b0;
   logic [CW-1:0] mst_n, mst_p, slv_n, slv_p;
   logic          busy, done, tmo;

   int thr_n = 0, thr_p = 0;
   bit am_en = 1'b1, as_en = 1'b1;
   int vectors = 0, fails = 0;

   always #5 clk = ~clk;

   assign cmp   = trial_p ? (int'(trial_code) >= thr_p) : (int'(trial_code) >= thr_n);
   assign ack_m = req_m & am_en;
   assign ack_s = req_s & as_en;

   drv_imp_cal #(.CODE_W(CW), .WAIT_W(WW), .ACK_LIMIT(64)) i_drv_imp_cal (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_i(settle), .cmp_i(cmp),
      .trial_code_o(trial_code), .trial_p_o(trial_p),
      .ack_mst_i(ack_m), .ack_slv_i(ack_s), .req_mst_o(req_m), .req_slv_o(req_s),
      .shadow_apply_i(apply),
      .mst_n_o(mst_n), .mst_p_o(mst_p), .slv_n_o(slv_n), .slv_p_o(slv_p),
      .busy_o(busy), .done_o(done), .timeout_o(tmo)
   );

   function automatic int exp_code(int thr);
      return (thr <= 15) ? thr : 16;
   endfunction

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   // one run; mid_apply pulses shadow_apply while the slave request is pending
   int hold2, saw_p, saw_slv_alone;
   task automatic run(int tn, int tp, int st, bit am, bit as_, bit mid_apply);
      bit applied = 1'b0;
      bit ok = 1'b0;
      thr_n = tn; thr_p = tp; settle = WW'(st); am_en = am; as_en = as_;
      hold2 = 0; saw_p = 0; saw_slv_alone = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R10 done cleared", int'(done), 0);
      check("R10 timeout cleared", int'(tmo), 0);
      check("R2 busy after start", int'(busy), 1);
      check("R2 nfet first", int'(trial_p), 0);
      for (int i = 0; i < 5000; i++) begin
         if (done) begin ok = 1'b1; break; end
         if (busy && !trial_p && trial_code == CW'(2)) hold2++;
         if (trial_p) saw_p = 1;
         if (req_s && !req_m) saw_slv_alone = 1;
         apply = 1'b0;
         if (mid_apply && req_s && !applied) begin apply = 1'b1; applied = 1'b1; end
         @(negedge clk);
      end
      apply = 1'b0;
      check("R2 run completes", int'(ok), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin
      int sh_n, sh_p;
      void'($urandom(32'h5eed_0c41));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mst_n reset", mst_n, 16);
      check("R1 mst_p reset", mst_p, 16);
      check("R1 slv_n reset", slv_n, 16);
      check("R1 slv_p reset", slv_p, 16);
      check("R1 busy reset", int'(busy), 0);
      check("R1 done reset", int'(done), 0);
      check("R1 timeout reset", int'(tmo), 0);
      check("R1 req reset", int'(req_m | req_s), 0);

      // directed first run: becomes the shadow
      run(5, 9, 3, 1, 1, 0);
      sh_n = 5; sh_p = 9;
      check("R4 nfet result", mst_n, 5);
      check("R4 pfet result", mst_p, 9);
      check("R5 slave nfet", slv_n, 5);
      check("R5 slave pfet", slv_p, 9);
      check("R6 no timeout", int'(tmo), 0);
      check("R3 hold of code 2", hold2, 4);
      check("R2 pfet phase seen", saw_p, 1);

      // saturation on nfet, immediate match on pfet
      run(20, 0, 0, 1, 1, 0);
      check("R4 nfet saturates", mst_n, 16);
      check("R4 pfet at zero", mst_p, 0);
      check("R5 slave saturated", slv_n, 16);

      // slave controller silent: timeout, request held alone, codes still out
      run(7, 3, 1, 1, 0, 0);
      check("R7 timeout raised", int'(tmo), 1);
      check("R7 done raised", int'(done), 1);
      check("R7 nfet published", mst_n, 7);
      check("R7 pfet published", mst_p, 3);
      check("R6 slave request outlives master", saw_slv_alone, 1);

      // apply during wait is ignored
      run(7, 3, 2, 1, 0, 1);
      check("R9 mid-run apply ignored n", mst_n, 7);
      check("R9 mid-run apply ignored p", mst_p, 3);
      check("R9 mid-run apply ignored slave", slv_p, 3);

      // apply when done copies the first run's codes
      @(negedge clk); apply = 1'b1;
      @(negedge clk); apply = 1'b0;
      check("R9 R8 shadow to mst_n", mst_n, sh_n);
      check("R9 R8 shadow to mst_p", mst_p, sh_p);
      check("R9 R8 shadow to slv_n", slv_n, sh_n);
      check("R9 R8 shadow to slv_p", slv_p, sh_p);

      // random runs
      for (int k = 0; k < 12; k++) begin
         int tn = int'($urandom_range(0, 20));
         int tp = int'($urandom_range(0, 20));
         int st = int'($urandom_range(0, 3));
         bit am = bit'($urandom_range(0, 3) != 0);
         bit as_ = bit'($urandom_range(0, 3) != 0);
         run(tn, tp, st, am, as_, 0);
         check("R4 random nfet", mst_n, exp_code(tn));
         check("R4 random pfet", mst_p, exp_code(tp));
         check("R5 random slave n", slv_n, exp_code(tn));
         check("R5 random slave p", slv_p, exp_code(tp));
         check("R6 R7 random timeout", int'(tmo), int'(!(am && as_)));
      end

      // shadow still holds the first run
      @(negedge clk); apply = 1'b1;
      @(negedge clk); apply = 1'b0;
      check("R8 shadow kept n", slv_n, sh_n);
      check("R8 shadow kept p", slv_p, sh_p);

      summary();
      $finish;
   end
endmodule